// File: doc/BRIEF.md
# Stereo Pixel Interleaver

The block merges two eye streams, a top-eye stream and a bottom-eye stream, that arrive in lockstep into one pixel stream. On each accepted beat it picks one of the two pixels according to a packing pattern (whole plane, alternate lines, alternate columns or a checkerboard) and according to the current eye polarity. It reports which eye it chose and the polarity in force.

The position of each beat is rebuilt inside the block from three markers that travel with the pixel: frame start, field start and line start. Polarity is held in a register. It can be flipped at every frame start or at every field start. A one-shot force request can also pin the polarity that the next frame or the next field begins with.

When the block is the lowest layer of a blend chain, the mix enable must be held low. In that case the top stream passes through unchanged.

Top module: `stereo_interleaver`

## Requirements
- R1: After reset, `out_valid_o`, `out_eye_o`, `out_pix_o` and `polarity_o` are all zero, so the first frame starts on the top eye.
- R2: Each beat with `in_valid_i` high yields exactly one output beat on the next clock. `out_pix_o` equals `bot_pix_i` of that beat when `out_eye_o` is 1, and `top_pix_i` when `out_eye_o` is 0. No output beat appears without an input beat.
- R3: Pattern code 0, and every odd code (1, 3, 5, 7), select whole-plane mode. In this mode `out_eye_o` equals the polarity in force for the beat.
- R4: Pattern code 2 (line interleave): `out_eye_o` = line index bit 0 XOR polarity.
- R5: Pattern code 4 (column interleave): `out_eye_o` = column index bit 0 XOR polarity.
- R6: Pattern code 6 (checkerboard): `out_eye_o` = column bit 0 XOR line bit 0 XOR polarity.
- R7: A beat with frame start or field start sits at column 0, line 0. A beat with line start alone sits at column 0 of the next line. Any other beat advances the column by one. Cycles without `in_valid_i` move nothing.
- R8: With `frame_alt_i` high, the polarity inverts on each frame-start beat. With `field_alt_i` high, it inverts on each field-start beat that is not also a frame-start beat. A frame start takes priority over a field start on the same beat.
- R9: A pulse on `force_load_i` samples both force codes: 2 forces polarity 0, 3 forces polarity 1, and 0 or 1 clears any pending force. A pending frame force overrides frame alternation at the next frame-start beat and is then cleared. A pending field force acts the same way at the next field-start beat.
- R10: `polarity_o` changes only on the clock edge that takes a frame-start or field-start beat. The new value already applies to that beat's eye choice.
- R11: With `mix_en_i` low, `out_eye_o` is 0 and `out_pix_o` is the top pixel. Polarity tracking continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mix_en_i | input | 1 | Stereo mix enable |
| pattern_i | input | 3 | Packing pattern code |
| frame_alt_i | input | 1 | Invert polarity at each frame start |
| field_alt_i | input | 1 | Invert polarity at each field start |
| force_load_i | input | 1 | Sample both force codes this cycle |
| frame_force_i | input | 2 | Next-frame polarity force code |
| field_force_i | input | 2 | Next-field polarity force code |
| in_valid_i | input | 1 | Input beat valid |
| frame_start_i | input | 1 | Beat is first of a frame |
| field_start_i | input | 1 | Beat is first of a field |
| line_start_i | input | 1 | Beat is first of a line |
| top_pix_i | input | PIX_W | Top-eye pixel |
| bot_pix_i | input | PIX_W | Bottom-eye pixel |
| out_valid_o | output | 1 | Output beat valid |
| out_pix_o | output | PIX_W | Selected pixel |
| out_eye_o | output | 1 | Selected eye, 1 = bottom |
| polarity_o | output | 1 | Registered eye polarity |

## Verification
Every output of a beat (valid, pixel, eye) appears exactly one clock after the rising edge that accepts the beat. The polarity update for a boundary beat lands on that same edge. The bench drives each beat on a falling edge and, at that moment, pushes the expected pixel, eye and polarity into a FIFO. A monitor on the next falling edge pops and compares one entry for each output beat, so the one-cycle latency is checked implicitly. Idle gaps and force loads between beats check that positions and pending forces move only on the documented events.

// File: rtl/stmix_pkg.sv
package stmix_pkg;

    typedef enum logic [1:0] {
        PAT_SINGLE = 2'd0,
        PAT_ROW    = 2'd1,
        PAT_COL    = 2'd2,
        PAT_CHECK  = 2'd3
    } pattern_e;

    typedef struct packed {
        logic armed;
        logic pol;
    } force_req_t;

    function automatic pattern_e decode_pattern(input logic [2:0] code);
        pattern_e p;
        p = PAT_SINGLE;
        if (!code[0]) begin
            case (code[2:1])
                2'd1:    p = PAT_ROW;
                2'd2:    p = PAT_COL;
                2'd3:    p = PAT_CHECK;
                default: p = PAT_SINGLE;
            endcase
        end
        return p;
    endfunction

    // code 2 -> force polarity 0, code 3 -> force polarity 1, else none
    function automatic force_req_t decode_force(input logic [1:0] code);
        force_req_t r;
        r.armed = code[1];
        r.pol   = code[0];
        return r;
    endfunction

endpackage

// File: rtl/stmix_pos_track.sv
module stmix_pos_track #(
    parameter int X_W = 12,
    parameter int Y_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_i,
    input  logic restart_i,
    input  logic line_i,
    output logic x_lsb_o,
    output logic y_lsb_o
);

    typedef struct packed {
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
    } pos_t;

    pos_t pos_q, pos_d, cur;

    always_comb begin
        cur = pos_q;
        if (restart_i) begin
            cur.x = '0;
            cur.y = '0;
        end else if (line_i) begin
            cur.x = '0;
            cur.y = pos_q.y + 1'b1;
        end else begin
            cur.x = pos_q.x + 1'b1;
        end
        pos_d = beat_i ? cur : pos_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign x_lsb_o = cur.x[0];
    assign y_lsb_o = cur.y[0];

endmodule

// File: rtl/stmix_pol_ctrl.sv
module stmix_pol_ctrl
    import stmix_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat_i,
    input  logic       frame_i,
    input  logic       field_i,
    input  logic       frame_alt_i,
    input  logic       field_alt_i,
    input  logic       load_i,
    input  logic [1:0] frame_code_i,
    input  logic [1:0] field_code_i,
    output logic       pol_cur_o,
    output logic       pol_o
);

    typedef struct packed {
        logic       pol;
        force_req_t fr;
        force_req_t fl;
    } pol_st_t;

    pol_st_t st_q, st_d;
    logic    pol_cur;

    always_comb begin
        st_d    = st_q;
        pol_cur = st_q.pol;
        if (beat_i && frame_i) begin
            if (st_q.fr.armed) begin
                pol_cur        = st_q.fr.pol;
                st_d.fr.armed  = 1'b0;
            end else if (frame_alt_i) begin
                pol_cur = ~st_q.pol;
            end
        end else if (beat_i && field_i) begin
            if (st_q.fl.armed) begin
                pol_cur        = st_q.fl.pol;
                st_d.fl.armed  = 1'b0;
            end else if (field_alt_i) begin
                pol_cur = ~st_q.pol;
            end
        end
        st_d.pol = pol_cur;
        if (load_i) begin
            st_d.fr = decode_force(frame_code_i);
            st_d.fl = decode_force(field_code_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pol_cur_o = pol_cur;
    assign pol_o     = st_q.pol;

endmodule

// File: rtl/stmix_eye_sel.sv
module stmix_eye_sel
    import stmix_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_i,
    input  logic             en_i,
    input  logic [2:0]       pattern_i,
    input  logic             x_lsb_i,
    input  logic             y_lsb_i,
    input  logic             pol_i,
    input  logic [PIX_W-1:0] top_pix_i,
    input  logic [PIX_W-1:0] bot_pix_i,
    output logic             out_valid_o,
    output logic [PIX_W-1:0] out_pix_o,
    output logic             out_eye_o
);

    typedef struct packed {
        logic             valid;
        logic             eye;
        logic [PIX_W-1:0] pix;
    } out_t;

    out_t     o_q, o_d;
    pattern_e pat;
    logic     phase;
    logic     eye;

    always_comb begin
        pat = decode_pattern(pattern_i);
        case (pat)
            PAT_ROW:   phase = y_lsb_i;
            PAT_COL:   phase = x_lsb_i;
            PAT_CHECK: phase = x_lsb_i ^ y_lsb_i;
            default:   phase = 1'b0;
        endcase
        eye = en_i & (phase ^ pol_i);

        o_d       = o_q;
        o_d.valid = beat_i;
        if (beat_i) begin
            o_d.eye = eye;
            o_d.pix = eye ? bot_pix_i : top_pix_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid_o = o_q.valid;
    assign out_pix_o   = o_q.pix;
    assign out_eye_o   = o_q.eye;

endmodule

// File: rtl/stereo_interleaver.sv
module stereo_interleaver #(
    parameter int PIX_W = 24,
    parameter int X_W   = 12,
    parameter int Y_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mix_en_i,
    input  logic [2:0]       pattern_i,
    input  logic             frame_alt_i,
    input  logic             field_alt_i,
    input  logic             force_load_i,
    input  logic [1:0]       frame_force_i,
    input  logic [1:0]       field_force_i,
    input  logic             in_valid_i,
    input  logic             frame_start_i,
    input  logic             field_start_i,
    input  logic             line_start_i,
    input  logic [PIX_W-1:0] top_pix_i,
    input  logic [PIX_W-1:0] bot_pix_i,
    output logic             out_valid_o,
    output logic [PIX_W-1:0] out_pix_o,
    output logic             out_eye_o,
    output logic             polarity_o
);

    logic restart;
    logic x_lsb, y_lsb;
    logic pol_cur;

    assign restart = frame_start_i | field_start_i;

    stmix_pos_track #(.X_W(X_W), .Y_W(Y_W)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_i    (in_valid_i),
        .restart_i (restart),
        .line_i    (line_start_i),
        .x_lsb_o   (x_lsb),
        .y_lsb_o   (y_lsb)
    );

    stmix_pol_ctrl u_pol (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat_i       (in_valid_i),
        .frame_i      (frame_start_i),
        .field_i      (field_start_i),
        .frame_alt_i  (frame_alt_i),
        .field_alt_i  (field_alt_i),
        .load_i       (force_load_i),
        .frame_code_i (frame_force_i),
        .field_code_i (field_force_i),
        .pol_cur_o    (pol_cur),
        .pol_o        (polarity_o)
    );

    stmix_eye_sel #(.PIX_W(PIX_W)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat_i      (in_valid_i),
        .en_i        (mix_en_i),
        .pattern_i   (pattern_i),
        .x_lsb_i     (x_lsb),
        .y_lsb_i     (y_lsb),
        .pol_i       (pol_cur),
        .top_pix_i   (top_pix_i),
        .bot_pix_i   (bot_pix_i),
        .out_valid_o (out_valid_o),
        .out_pix_o   (out_pix_o),
        .out_eye_o   (out_eye_o)
    );

endmodule

// File: rtl/stereo_interleaver_chk.sv
module stereo_interleaver_chk #(
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mix_en_i,
    input logic [2:0]       pattern_i,
    input logic             in_valid_i,
    input logic             frame_start_i,
    input logic             field_start_i,
    input logic [PIX_W-1:0] top_pix_i,
    input logic [PIX_W-1:0] bot_pix_i,
    input logic             out_valid_o,
    input logic [PIX_W-1:0] out_pix_o,
    input logic             out_eye_o,
    input logic             polarity_o
);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);

    a_r2_no_spurious_out: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);

    a_r2_pix_from_eye: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (out_pix_o == (out_eye_o ? $past(bot_pix_i) : $past(top_pix_i))));

    a_r3_single_tracks_pol: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && mix_en_i && (pattern_i[0] || pattern_i[2:1] == 2'b00))
        |=> (out_eye_o == polarity_o));

    a_r10_pol_moves_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (polarity_o != $past(polarity_o)) |-> $past(in_valid_i && (frame_start_i || field_start_i)));

    a_r11_disabled_passes_top: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !mix_en_i) |=> (!out_eye_o && out_pix_o == $past(top_pix_i)));

endmodule

bind stereo_interleaver stereo_interleaver_chk #(.PIX_W(PIX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mix_en_i      (mix_en_i),
    .pattern_i     (pattern_i),
    .in_valid_i    (in_valid_i),
    .frame_start_i (frame_start_i),
    .field_start_i (field_start_i),
    .top_pix_i     (top_pix_i),
    .bot_pix_i     (bot_pix_i),
    .out_valid_o   (out_valid_o),
    .out_pix_o     (out_pix_o),
    .out_eye_o     (out_eye_o),
    .polarity_o    (polarity_o)
);

// File: tb/test_stereo_interleaver.sv
module test_stereo_interleaver;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W      = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mix_en = 1'b0;
    logic [2:0]       pattern = 3'd0;
    logic             frame_alt = 1'b0;
    logic             field_alt = 1'b0;
    logic             force_load = 1'b0;
    logic [1:0]       frame_force = 2'd0;
    logic [1:0]       field_force = 2'd0;
    logic             in_valid = 1'b0;
    logic             sof = 1'b0;
    logic             sofld = 1'b0;
    logic             sol = 1'b0;
    logic [PIX_W-1:0] top_pix = '0;
    logic [PIX_W-1:0] bot_pix = '0;
    logic             out_valid;
    logic [PIX_W-1:0] out_pix;
    logic             out_eye;
    logic             polarity;

    always #(CLK_PERIOD/2) clk = ~clk;

    stereo_interleaver #(.PIX_W(PIX_W)) i_stereo_interleaver (
        .clk           (clk),
        .rst_n         (rst_n),
        .mix_en_i      (mix_en),
        .pattern_i     (pattern),
        .frame_alt_i   (frame_alt),
        .field_alt_i   (field_alt),
        .force_load_i  (force_load),
        .frame_force_i (frame_force),
        .field_force_i (field_force),
        .in_valid_i    (in_valid),
        .frame_start_i (sof),
        .field_start_i (sofld),
        .line_start_i  (sol),
        .top_pix_i     (top_pix),
        .bot_pix_i     (bot_pix),
        .out_valid_o   (out_valid),
        .out_pix_o     (out_pix),
        .out_eye_o     (out_eye),
        .polarity_o    (polarity)
    );

    typedef struct {
        logic [PIX_W-1:0] pix;
        logic             eye;
        logic             pol;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;

    // reference state
    int   mx = 0;
    int   my = 0;
    logic mpol = 1'b0;
    logic fr_v = 1'b0, fr_p = 1'b0, fl_v = 1'b0, fl_p = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic beat(input logic [PIX_W-1:0] t, input logic [PIX_W-1:0] b,
                        input logic f, input logic l, input logic d, input string tag);
        exp_t e;
        logic ph;
        if (f || d) begin mx = 0; my = 0; end
        else if (l) begin mx = 0; my = my + 1; end
        else mx = mx + 1;
        if (f) begin
            if (fr_v) begin mpol = fr_p; fr_v = 1'b0; end
            else if (frame_alt) mpol = ~mpol;
        end else if (d) begin
            if (fl_v) begin mpol = fl_p; fl_v = 1'b0; end
            else if (field_alt) mpol = ~mpol;
        end
        case (pattern)
            3'd2:    ph = my[0];
            3'd4:    ph = mx[0];
            3'd6:    ph = mx[0] ^ my[0];
            default: ph = 1'b0;
        endcase
        e.eye = mix_en & (ph ^ mpol);
        e.pix = e.eye ? b : t;
        e.pol = mpol;
        e.tag = tag;
        exp_q.push_back(e);
        in_valid = 1'b1; top_pix = t; bot_pix = b; sof = f; sol = l; sofld = d;
        @(negedge clk);
        in_valid = 1'b0; sof = 1'b0; sol = 1'b0; sofld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_force(input logic [1:0] frc, input logic [1:0] flc);
        force_load = 1'b1; frame_force = frc; field_force = flc;
        fr_v = frc[1]; fr_p = frc[0];
        fl_v = flc[1]; fl_p = flc[0];
        @(negedge clk);
        force_load = 1'b0; frame_force = 2'd0; field_force = 2'd0;
    endtask

    // frame of `lines` x `px`; a field start is placed at line fld_line when > 0
    task automatic frame_gen(input int lines, input int px, input int fld_line, input string tag);
        for (int l = 0; l < lines; l++) begin
            for (int p = 0; p < px; p++) begin
                beat(PIX_W'(24'h100000 + l*16 + p), PIX_W'(24'h200000 + l*16 + p),
                     (l == 0 && p == 0), (l > 0 && p == 0),
                     (fld_line > 0 && l == fld_line && p == 0), tag);
            end
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected output beat", 32'(out_pix), 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_pix == e.pix, e.tag, "pixel", 32'(out_pix), 32'(e.pix));
                check(out_eye == e.eye, e.tag, "eye", 32'(out_eye), 32'(e.eye));
                check(polarity == e.pol, "R10", {"polarity in ", e.tag}, 32'(polarity), 32'(e.pol));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1", "out_valid", 32'(out_valid), 32'h0);
        check(out_eye == 1'b0, "R1", "out_eye", 32'(out_eye), 32'h0);
        check(out_pix == '0, "R1", "out_pix", 32'(out_pix), 32'h0);
        check(polarity == 1'b0, "R1", "polarity", 32'(polarity), 32'h0);

        mix_en = 1'b1;
        pattern = 3'd0; frame_gen(2, 3, 0, "R3 whole plane");
        pattern = 3'd2; frame_gen(3, 3, 0, "R4 line interleave");
        pattern = 3'd4; frame_gen(2, 4, 0, "R5 column interleave");
        pattern = 3'd6; frame_gen(3, 3, 0, "R6 checkerboard");
        pattern = 3'd5; frame_gen(2, 2, 0, "R3 odd code");
        pattern = 3'd3; frame_gen(1, 2, 0, "R3 odd code 3");

        // R7 idle gaps do not advance the column
        pattern = 3'd4;
        beat(24'h111111, 24'h222222, 1'b1, 1'b0, 1'b0, "R7 gap");
        idle(2);
        beat(24'h111112, 24'h222223, 1'b0, 1'b0, 1'b0, "R7 gap");
        idle(1);
        beat(24'h111113, 24'h222224, 1'b0, 1'b0, 1'b0, "R7 gap");
        beat(24'h111114, 24'h222225, 1'b0, 1'b1, 1'b0, "R7 line start");

        // R8 frame alternation
        pattern = 3'd2; frame_alt = 1'b1;
        repeat (3) frame_gen(2, 2, 0, "R8 frame alternate");
        // R8 field alternation
        frame_alt = 1'b0; field_alt = 1'b1; pattern = 3'd6;
        repeat (2) frame_gen(4, 2, 2, "R8 field alternate");
        // R8 frame start beats field start on the same beat
        frame_alt = 1'b0; field_alt = 1'b1; pattern = 3'd0;
        beat(24'h0A0A0A, 24'h0B0B0B, 1'b1, 1'b0, 1'b1, "R8 frame priority");

        // R9 forces
        field_alt = 1'b0; frame_alt = 1'b1; pattern = 3'd2;
        load_force(2'd3, 2'd0);
        frame_gen(2, 2, 0, "R9 force bottom");
        frame_gen(2, 2, 0, "R9 force cleared");
        load_force(2'd2, 2'd0);
        frame_gen(2, 2, 0, "R9 force top");
        frame_gen(1, 2, 0, "R9 force top cleared");
        frame_alt = 1'b0; pattern = 3'd0;
        load_force(2'd0, 2'd3);
        frame_gen(4, 2, 2, "R9 field force");
        load_force(2'd0, 2'd2);
        frame_gen(4, 2, 2, "R9 field force top");
        load_force(2'd3, 2'd0);
        load_force(2'd1, 2'd0);
        frame_gen(2, 2, 0, "R9 force cancelled");

        // R11 mix disabled
        mix_en = 1'b0; frame_alt = 1'b1; pattern = 3'd6;
        repeat (2) frame_gen(2, 2, 0, "R11 disabled");

        idle(3);
        check(exp_q.size() == 0, "R2", "beats left unanswered", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule